// File: doc/BRIEF.md
# Polynomial Bilinear Transform Engine

This engine maps the integer coefficients of a degree-n polynomial P(z) onto the coefficients of the polynomial in s obtained by substituting z = (s+1)/(s-1) and clearing the denominator. The result is the polynomial (s-1)^n · P((s+1)/(s-1)). The mapping is done as a chain of in-place coefficient passes over one signed register array. An upward unit shift of the argument comes first. A combined reversal and power-of-two root scaling follows. A downward unit shift of the argument comes last. Every update is an add, a subtract or a shift, so the block has no multiplier and no divider. The polynomial is never normalised to monic form, so no division is needed anywhere.

A client applies the coefficients on a parallel bus, together with the actual degree, and pulses start. The engine raises busy while it works. One update is made per clock cycle. At the end it pulses done for one cycle and holds the result on the output bus until the next accepted start. The internal registers are wider than the inputs by a set of guard bits. Any intermediate value that does not fit saturates, and a sticky flag reports it.

Top module: `bilin_xform`

## Requirements
- R1: Output field j, at bits [j*ACC_W +: ACC_W] of `coef_o`, is the signed coefficient of s^j in (s-1)^n·P((s+1)/(s-1)). Input field j, at bits [j*IN_W +: IN_W] of `coef_i`, is the signed coefficient of z^j. ACC_W = IN_W + GUARD_W.
- R2: With degree 4 and input coefficients (z^4..z^0) = 2,4,6,5,1, the output (s^4..s^0) is 18,2,6,6,0.
- R3: If an intermediate value leaves the signed ACC_W range, it is clamped to the nearest bound and `ovf_o` goes high. `ovf_o` stays high until the next accepted start clears it.
- R4: For an effective degree n, `busy_o` is high for exactly n*n+n+1 cycles after the clock edge that accepts start. `done_o` is high for exactly the first cycle in which `busy_o` is low again.
- R5: For an effective degree n below MAX_DEG, input fields above n are ignored and output fields above n read zero.
- R6: A `deg_i` value above MAX_DEG is treated as MAX_DEG.
- R7: A start asserted while `busy_o` is high is ignored. The run in progress finishes with its own data, degree and latency.
- R8: While the block is idle and start is low, `coef_o` and `ovf_o` do not change, whatever `coef_i` and `deg_i` do.
- R9: Degree 0 returns field 0 unchanged and busy lasts one cycle.
- R10: After reset, `busy_o`, `done_o` and `ovf_o` are low and `coef_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transform; sampled only while idle |
| deg_i | input | $clog2(MAX_DEG+1) | Degree of the input polynomial |
| coef_i | input | (MAX_DEG+1)*IN_W | Signed input coefficients, field j is z^j |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Sticky saturation flag of the last run |
| coef_o | output | (MAX_DEG+1)*(IN_W+GUARD_W) | Signed result coefficients, field j is s^j |

## Verification
The bench builds the engine with MAX_DEG = 4, IN_W = 8 and GUARD_W = 4, which gives a 12-bit internal range. With these values, full-scale degree-4 inputs drive the scaling and downward-shift passes past the range, so saturation and the sticky flag are actually exercised. Inputs of small magnitude stay exact and can be compared with a closed-form expansion. Degree 1 is swept exhaustively over the coefficient range -8..7. Degrees 0 to 4 are covered by pseudo-random full-scale and small-scale patterns. The run order of the bench also covers degree clamping, starts while busy and idle hold behaviour.

// File: rtl/bxf_pkg.sv
package bxf_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_ADD,
    OP_SUB,
    OP_FLIP
  } bxf_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_UP,
    S_FLIP,
    S_DN
  } bxf_state_e;
endpackage

// File: rtl/bxf_seq.sv
module bxf_seq
  import bxf_pkg::*;
#(
  parameter int MAX_DEG = 4,
  parameter int IDX_W   = $clog2(MAX_DEG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] deg_i,
  output logic             busy_o,
  output logic             done_o,
  output bxf_op_e          op_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] deg_o
);
  bxf_state_e       state_q;
  logic [IDX_W-1:0] i_q, j_q, deg_q;
  logic             done_q;
  logic             last_j, last_i;

  assign last_j = (j_q == i_q);
  assign last_i = (i_q == IDX_W'(deg_q - 1'b1));

  always_comb begin
    op_o = OP_IDLE;
    unique case (state_q)
      S_IDLE:  if (start_i) op_o = OP_LOAD;
      S_UP:    op_o = OP_ADD;
      S_FLIP:  op_o = OP_FLIP;
      S_DN:    op_o = OP_SUB;
      default: op_o = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      i_q     <= '0;
      j_q     <= '0;
      deg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          deg_q   <= deg_i;
          i_q     <= '0;
          j_q     <= IDX_W'(deg_i - 1'b1);
          state_q <= (deg_i == '0) ? S_FLIP : S_UP;
        end
        S_UP, S_DN: begin
          if (last_j) begin
            if (last_i) begin
              state_q <= (state_q == S_UP) ? S_FLIP : S_IDLE;
              done_q  <= (state_q == S_DN);
            end else begin
              i_q <= i_q + 1'b1;
              j_q <= IDX_W'(deg_q - 1'b1);
            end
          end else begin
            j_q <= j_q - 1'b1;
          end
        end
        S_FLIP: begin
          if (deg_q == '0) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= S_DN;
            i_q     <= '0;
            j_q     <= IDX_W'(deg_q - 1'b1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign idx_o  = j_q;
  assign deg_o  = deg_q;
endmodule

// File: rtl/bxf_datapath.sv
module bxf_datapath
  import bxf_pkg::*;
#(
  parameter int MAX_DEG = 4,
  parameter int IN_W    = 16,
  parameter int ACC_W   = 24,
  parameter int IDX_W   = $clog2(MAX_DEG + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  bxf_op_e                      op_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [IDX_W-1:0]             deg_i,
  input  logic [(MAX_DEG+1)*IN_W-1:0]  coef_i,
  output logic [(MAX_DEG+1)*ACC_W-1:0] coef_o,
  output logic                         ovf_o
);
  localparam int NUM_C  = MAX_DEG + 1;
  localparam int WIDE_W = ACC_W + MAX_DEG + 1;
  localparam logic signed [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  cr_q [NUM_C];
  logic signed [ACC_W-1:0]  cr_d [NUM_C];
  logic                     ovf_q, ovf_d;
  logic signed [ACC_W-1:0]  lo_v, hi_v;
  logic signed [ACC_W:0]    sum_w;
  logic signed [WIDE_W-1:0] wide;
  logic [IDX_W-1:0]         hi_idx;
  int                       dg;

  assign hi_idx = idx_i + IDX_W'(1);
  assign dg     = int'(deg_i);

  always_comb begin
    cr_d  = cr_q;
    ovf_d = ovf_q;
    wide  = '0;
    lo_v  = cr_q[idx_i];
    hi_v  = cr_q[hi_idx];
    // one extra bit catches the carry into the sign
    if (op_i == OP_SUB) sum_w = {lo_v[ACC_W-1], lo_v} - {hi_v[ACC_W-1], hi_v};
    else                sum_w = {lo_v[ACC_W-1], lo_v} + {hi_v[ACC_W-1], hi_v};
    unique case (op_i)
      OP_LOAD: begin
        ovf_d = 1'b0;
        for (int k = 0; k < NUM_C; k++)
          cr_d[k] = (k <= dg) ? ACC_W'(signed'(coef_i[k*IN_W +: IN_W])) : '0;
      end
      OP_ADD, OP_SUB: begin
        if (sum_w[ACC_W] != sum_w[ACC_W-1]) begin
          cr_d[idx_i] = sum_w[ACC_W] ? MIN_V : MAX_V;
          ovf_d       = 1'b1;
        end else begin
          cr_d[idx_i] = sum_w[ACC_W-1:0];
        end
      end
      OP_FLIP: begin
        // reverse order and scale degree j by 2^(n-j) in one step
        for (int k = 0; k < NUM_C; k++) begin
          if (k <= dg) begin
            wide = WIDE_W'(cr_q[dg-k]) <<< (dg - k);
            if (wide > WIDE_W'(MAX_V)) begin
              cr_d[k] = MAX_V;
              ovf_d   = 1'b1;
            end else if (wide < WIDE_W'(MIN_V)) begin
              cr_d[k] = MIN_V;
              ovf_d   = 1'b1;
            end else begin
              cr_d[k] = wide[ACC_W-1:0];
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_C; k++) cr_q[k] <= '0;
      ovf_q <= 1'b0;
    end else begin
      cr_q  <= cr_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < NUM_C; g++) begin : g_out
    assign coef_o[g*ACC_W +: ACC_W] = cr_q[g];
  end
  assign ovf_o = ovf_q;
endmodule

// File: rtl/bilin_xform.sv
module bilin_xform
  import bxf_pkg::*;
#(
  parameter int MAX_DEG = 4,
  parameter int IN_W    = 16,
  parameter int GUARD_W = 2 * MAX_DEG
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   start_i,
  input  logic [$clog2(MAX_DEG+1)-1:0]           deg_i,
  input  logic [(MAX_DEG+1)*IN_W-1:0]            coef_i,
  output logic                                   busy_o,
  output logic                                   done_o,
  output logic                                   ovf_o,
  output logic [(MAX_DEG+1)*(IN_W+GUARD_W)-1:0]  coef_o
);
  localparam int IDX_W = $clog2(MAX_DEG + 1);
  localparam int ACC_W = IN_W + GUARD_W;

  bxf_op_e          op_cur;
  logic [IDX_W-1:0] idx_cur, deg_run, deg_clamp, deg_dp;

  assign deg_clamp = (deg_i > IDX_W'(MAX_DEG)) ? IDX_W'(MAX_DEG) : deg_i;
  assign deg_dp    = (op_cur == OP_LOAD) ? deg_clamp : deg_run;

  bxf_seq #(.MAX_DEG(MAX_DEG), .IDX_W(IDX_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .deg_i  (deg_clamp),
    .busy_o (busy_o),
    .done_o (done_o),
    .op_o   (op_cur),
    .idx_o  (idx_cur),
    .deg_o  (deg_run)
  );

  bxf_datapath #(.MAX_DEG(MAX_DEG), .IN_W(IN_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_dp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op_cur),
    .idx_i (idx_cur),
    .deg_i (deg_dp),
    .coef_i(coef_i),
    .coef_o(coef_o),
    .ovf_o (ovf_o)
  );
endmodule

// File: rtl/bilin_xform_chk.sv
module bilin_xform_chk
  import bxf_pkg::*;
#(
  parameter int MAX_DEG = 4,
  parameter int IN_W    = 16,
  parameter int GUARD_W = 2 * MAX_DEG
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  start_i,
  input logic                                  busy_o,
  input logic                                  done_o,
  input logic                                  ovf_o,
  input logic [(MAX_DEG+1)*(IN_W+GUARD_W)-1:0] coef_o,
  input logic [$clog2(MAX_DEG+1)-1:0]          deg_run,
  input bxf_op_e                               op_cur
);
  localparam int ACC_W = IN_W + GUARD_W;

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r4_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ovf_o) |=> ovf_o);

  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |-> (op_cur != OP_LOAD));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(coef_o) && $stable(ovf_o)));

  for (genvar g = 1; g <= MAX_DEG; g++) begin : g_hi
    a_r5_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && (int'(deg_run) < g)) |-> (coef_o[g*ACC_W +: ACC_W] == '0));
  end
endmodule

bind bilin_xform bilin_xform_chk #(
  .MAX_DEG(MAX_DEG), .IN_W(IN_W), .GUARD_W(GUARD_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .ovf_o  (ovf_o),
  .coef_o (coef_o),
  .deg_run(deg_run),
  .op_cur (op_cur)
);

// File: tb/tb_bilin_xform.sv
module tb_bilin_xform;
  localparam int MD = 4;
  localparam int IW = 8;
  localparam int GW = 4;
  localparam int AW = IW + GW;
  localparam longint VMAX = (64'sd1 <<< (AW - 1)) - 1;
  localparam longint VMIN = -(64'sd1 <<< (AW - 1));

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   start_i = 1'b0;
  logic [2:0]             deg_i = '0;
  logic [(MD+1)*IW-1:0]   coef_i = '0;
  logic                   busy_o, done_o, ovf_o;
  logic [(MD+1)*AW-1:0]   coef_o;

  int checks = 0;
  int errors = 0;

  bilin_xform #(.MAX_DEG(MD), .IN_W(IW), .GUARD_W(GW)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  longint a_in [MD+1];
  longint m_c  [MD+1];
  longint cf   [MD+1];
  bit     m_ov;
  int     lat;
  int unsigned seed = 32'h1234_5678;

  function automatic longint sat(longint v);
    if (v > VMAX) begin m_ov = 1; return VMAX; end
    if (v < VMIN) begin m_ov = 1; return VMIN; end
    return v;
  endfunction

  function automatic longint outf(int j);
    return longint'($signed(coef_o[j*AW +: AW]));
  endfunction

  function automatic int unsigned nxt();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // saturating pass model from R1/R3
  task automatic model(input int n);
    longint t [MD+1];
    m_ov = 0;
    for (int j = 0; j <= MD; j++) m_c[j] = (j <= n) ? a_in[j] : 0;
    for (int i = 0; i < n; i++)
      for (int j = n - 1; j >= i; j--) m_c[j] = sat(m_c[j] + m_c[j+1]);
    for (int j = 0; j <= MD; j++) t[j] = (j <= n) ? sat(m_c[n-j] * (64'sd1 <<< (n - j))) : 0;
    for (int j = 0; j <= MD; j++) m_c[j] = t[j];
    for (int i = 0; i < n; i++)
      for (int j = n - 1; j >= i; j--) m_c[j] = sat(m_c[j] - m_c[j+1]);
  endtask

  // exact expansion of sum a_i (s+1)^i (s-1)^(n-i)
  task automatic closed(input int n);
    longint p [MD+1];
    for (int j = 0; j <= MD; j++) cf[j] = 0;
    for (int i = 0; i <= n; i++) begin
      for (int j = 0; j <= MD; j++) p[j] = 0;
      p[0] = a_in[i];
      for (int r = 0; r < i; r++)
        for (int k = MD; k >= 1; k--) p[k] = p[k] + p[k-1];
      for (int r = 0; r < n - i; r++) begin
        for (int k = MD; k >= 1; k--) p[k] = p[k-1] - p[k];
        p[0] = -p[0];
      end
      for (int j = 0; j <= MD; j++) cf[j] += p[j];
    end
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one transform; inject=1 pulses start with other data mid-run (R7)
  task automatic run(input int deg_drive, input bit inject, input string req);
    int n;
    n = (deg_drive > MD) ? MD : deg_drive;
    model(n);
    closed(n);
    @(negedge clk_i);
    for (int j = 0; j <= MD; j++) coef_i[j*IW +: IW] = a_in[j][IW-1:0];
    deg_i   = 3'(deg_drive);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (busy_o && lat < 100) begin
      lat++;
      if (inject && lat == 2) begin
        start_i = 1'b1;
        coef_i  = ~coef_i;
        deg_i   = 3'd1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(lat == n * n + n + 1, {req, " R4 latency"}, lat, n * n + n + 1);
    chk(done_o == 1'b1, {req, " R4 done"}, done_o, 1);
    chk(ovf_o == m_ov, {req, " R3 ovf"}, ovf_o, m_ov);
    for (int j = 0; j <= MD; j++) begin
      chk(outf(j) == m_c[j], {req, " R1 field"}, outf(j), m_c[j]);
      if (!m_ov) chk(outf(j) == cf[j], {req, " R1 exact"}, outf(j), cf[j]);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, {req, " R4 pulse"}, done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!busy_o && !done_o && !ovf_o, "R10 flags", {busy_o, done_o, ovf_o}, 0);
    chk(coef_o == '0, "R10 coef", longint'(coef_o != '0), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 worked example
    a_in[4] = 2; a_in[3] = 4; a_in[2] = 6; a_in[1] = 5; a_in[0] = 1;
    run(4, 0, "R2");
    chk(outf(4) == 18 && outf(3) == 2 && outf(2) == 6 && outf(1) == 6 && outf(0) == 0,
        "R2 literal", outf(3), 2);

    // R8 hold while idle with busy inputs
    for (int c = 0; c < 6; c++) begin
      coef_i = coef_i ^ 40'h5a_a5_3c_c3_0f;
      deg_i  = 3'(c);
      @(negedge clk_i);
    end
    chk(outf(4) == 18 && outf(1) == 6 && !ovf_o, "R8 hold", outf(4), 18);

    // R7 start during busy ignored
    run(4, 1, "R7");

    // R6 degree above maximum
    a_in[4] = 3; a_in[3] = -2; a_in[2] = 1; a_in[1] = 0; a_in[0] = -1;
    run(7, 0, "R6");

    // R5 upper fields ignored and zero
    a_in[4] = 99; a_in[3] = -77; a_in[2] = 3; a_in[1] = -5; a_in[0] = 2;
    run(2, 0, "R5");
    chk(outf(3) == 0 && outf(4) == 0, "R5 zero", outf(4), 0);

    // R9 degree zero
    a_in[0] = -100;
    run(0, 0, "R9");
    chk(outf(0) == -100, "R9 value", outf(0), -100);

    // R3 full-scale saturation
    for (int j = 0; j <= MD; j++) a_in[j] = 127;
    run(4, 0, "R3");
    chk(ovf_o == 1'b1, "R3 flag set", ovf_o, 1);
    a_in[0] = 1; a_in[1] = 1;
    run(1, 0, "R3 clear");
    chk(ovf_o == 1'b0, "R3 flag cleared", ovf_o, 0);

    // R1 exhaustive degree-1 sweep
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++) begin
        a_in[0] = x; a_in[1] = y;
        run(1, 0, "R1 deg1");
      end

    // R1 pseudo-random sweep over degrees 0..4
    for (int it = 0; it < 200; it++) begin
      for (int j = 0; j <= MD; j++) begin
        if (it % 2 == 1) a_in[j] = longint'(int'(nxt() % 255) - 127);
        else             a_in[j] = longint'(int'(nxt() % 15) - 7);
      end
      run(it % 5, 0, "R1 sweep");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule